// File: doc/BRIEF.md
# TDM Codec Frame Slot Handler

This block connects a serial time-division audio link to a sample-processing core. Each frame holds a fixed number of 16-bit slots, sent MSB first. A one-bit-clock sync pulse marks the first bit of slot 0. Only the first five slots carry traffic: a tag word, a control address word, a control data word, a left audio word and a right audio word. The remaining slots are idle.

On the receive side, the block deserialises the five active slots. It presents the status address and status data words, and it decodes the two request flags carried in the status address word. It releases a left or right capture sample to the core only when the matching valid flag is set in that frame's tag. As a result, audio can run at a rate below the frame rate.

On the transmit side, the core offers playback samples and a control command through strobes. At each sync pulse the block freezes the whole outgoing frame, tag and data together. The tag's valid flags therefore always travel in the same frame as the words they qualify.

Top module: `tdm_slot_handler`

## Requirements
- R1: A frame starts at the bit where fsync_i is high. Bits are counted MSB first in 16-bit slots, with slot index = bit position / 16. Received bits in slots 5 and above are ignored, and sdata_o is low throughout those slots.
- R2: After the last bit of slot 1, stat_addr_o holds that received word, dac_req_left_o holds its bit 7 and dac_req_right_o holds its bit 6. After the last bit of slot 2, stat_data_o holds the received slot 2 word.
- R3: If bit 12 of the received slot 0 word is set, the clock edge that samples the last bit of slot 4 loads the slot 3 word into cap_left_o. That same edge raises cap_left_new_o for exactly one cycle. At no other time does cap_left_new_o go high.
- R4: If bit 11 of the received slot 0 word is set, the same edge loads the slot 4 word into cap_right_o and raises cap_right_new_o for one cycle. At no other time does cap_right_new_o go high.
- R5: When a valid flag is clear, the matching capture output keeps its previous value and its strobe stays low.
- R6: sdata_o is registered. The bit for frame position p appears in the cycle after the edge that samples receive position p. Bit 15 of the transmitted slot 0 word is always 1.
- R7: Transmitted slot 0 bit 12 (left) and bit 11 (right) are 1 only if a playback strobe for that side arrived since the previous frame snapshot. Slots 3 and 4 carry the most recently loaded left and right playback words.
- R8: A cmd_vld_i strobe sets transmitted slot 0 bits 14 and 13 in the next frame snapshot. Slots 1 and 2 carry the most recently loaded command address and data words.
- R9: The outgoing frame is frozen on the fsync_i edge. A strobe arriving on that same edge, or later in the frame, only affects the following frame.
- R10: After reset and before the first fsync_i, all outputs are zero, sdata_o stays low and no capture strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | High for the first bit of slot 0 |
| sdata_i | input | 1 | Serial receive data, MSB first |
| sdata_o | output | 1 | Serial transmit data, one bit clock behind the receive frame |
| stat_addr_o | output | SLOT_W | Last received slot 1 word |
| stat_data_o | output | SLOT_W | Last received slot 2 word |
| dac_req_left_o | output | 1 | Left request flag from slot 1 |
| dac_req_right_o | output | 1 | Right request flag from slot 1 |
| cap_left_o | output | SLOT_W | Held left capture sample |
| cap_right_o | output | SLOT_W | Held right capture sample |
| cap_left_new_o | output | 1 | One-cycle strobe: new left sample |
| cap_right_new_o | output | 1 | One-cycle strobe: new right sample |
| pb_left_i | input | SLOT_W | Left playback sample |
| pb_left_vld_i | input | 1 | Load strobe for pb_left_i |
| pb_right_i | input | SLOT_W | Right playback sample |
| pb_right_vld_i | input | 1 | Load strobe for pb_right_i |
| cmd_addr_i | input | SLOT_W | Command address word |
| cmd_data_i | input | SLOT_W | Command data word |
| cmd_vld_i | input | 1 | Load strobe for the command pair |

## Verification
The bench keeps SLOT_W at 16 and builds the block with NUM_SLOTS = 8. This gives a 128-bit frame that still holds the five active slots plus three idle ones, so each frame runs quickly. Many frames can therefore run back to back.

Within that budget the bench covers every combination of the capture valid flags. It also checks that idle slots carrying all-ones are ignored. Playback and command strobes are placed mid-frame, inside slot 3 and on the sync edge itself. This exercises the rule that a frame's tag and data are frozen together.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned ACTIVE_SLOTS = 5;
  localparam logic [2:0] SLOT_TAG   = 3'd0;
  localparam logic [2:0] SLOT_ADDR  = 3'd1;
  localparam logic [2:0] SLOT_DATA  = 3'd2;
  localparam logic [2:0] SLOT_LEFT  = 3'd3;
  localparam logic [2:0] SLOT_RIGHT = 3'd4;
endpackage

// File: rtl/tdm_bit_timer.sv
// Frame position tracking; SLOT_W must be a power of two.
module tdm_bit_timer #(
  parameter int unsigned SLOT_W    = 16,
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned FRAME    = SLOT_W * NUM_SLOTS,
  localparam int unsigned CNT_W    = $clog2(FRAME),
  localparam int unsigned BIT_IW   = $clog2(SLOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  output logic              synced_o,
  output logic              active_o,
  output logic              last_o,
  output logic [2:0]        slot_o,
  output logic [BIT_IW-1:0] bit_o
);
  logic [CNT_W-1:0] cnt_q, pos, slot_full, rem;
  logic             synced_q;

  assign synced_o  = fsync_i | synced_q;
  assign pos       = fsync_i ? '0 : cnt_q;
  assign slot_full = pos / CNT_W'(SLOT_W);
  assign rem       = pos % CNT_W'(SLOT_W);
  assign active_o  = synced_o && (slot_full < CNT_W'(tdm_pkg::ACTIVE_SLOTS));
  assign slot_o    = active_o ? 3'(slot_full) : 3'd0;
  assign last_o    = (rem == CNT_W'(SLOT_W - 1));
  assign bit_o     = BIT_IW'(CNT_W'(SLOT_W - 1) - rem);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      cnt_q    <= (pos == CNT_W'(FRAME - 1)) ? '0 : pos + 1'b1;
      synced_q <= synced_o;
    end
  end
endmodule

// File: rtl/tdm_rx_deframer.sv
module tdm_rx_deframer #(
  parameter int unsigned SLOT_W     = 16,
  parameter int unsigned L_VLD_BIT  = 12,
  parameter int unsigned R_VLD_BIT  = 11,
  parameter int unsigned REQ_L_BIT  = 7,
  parameter int unsigned REQ_R_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              active_i,
  input  logic              last_i,
  input  logic [2:0]        slot_i,
  output logic [SLOT_W-1:0] stat_addr_o,
  output logic [SLOT_W-1:0] stat_data_o,
  output logic              dac_req_left_o,
  output logic              dac_req_right_o,
  output logic [SLOT_W-1:0] cap_left_o,
  output logic [SLOT_W-1:0] cap_right_o,
  output logic              cap_left_new_o,
  output logic              cap_right_new_o
);
  logic [SLOT_W-2:0] sr_q;
  logic [SLOT_W-1:0] word, left_q;
  logic              tag_l_q, tag_r_q;

  assign word            = {sr_q, sdata_i};
  assign dac_req_left_o  = stat_addr_o[REQ_L_BIT];
  assign dac_req_right_o = stat_addr_o[REQ_R_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q            <= '0;
      left_q          <= '0;
      tag_l_q         <= 1'b0;
      tag_r_q         <= 1'b0;
      stat_addr_o     <= '0;
      stat_data_o     <= '0;
      cap_left_o      <= '0;
      cap_right_o     <= '0;
      cap_left_new_o  <= 1'b0;
      cap_right_new_o <= 1'b0;
    end else begin
      sr_q            <= word[SLOT_W-2:0];
      cap_left_new_o  <= 1'b0;
      cap_right_new_o <= 1'b0;
      if (active_i && last_i) begin
        unique case (slot_i)
          tdm_pkg::SLOT_TAG: begin
            tag_l_q <= word[L_VLD_BIT];
            tag_r_q <= word[R_VLD_BIT];
          end
          tdm_pkg::SLOT_ADDR:  stat_addr_o <= word;
          tdm_pkg::SLOT_DATA:  stat_data_o <= word;
          tdm_pkg::SLOT_LEFT:  left_q      <= word;
          tdm_pkg::SLOT_RIGHT: begin
            // both channels released together once the frame's samples are in
            if (tag_l_q) begin
              cap_left_o     <= left_q;
              cap_left_new_o <= 1'b1;
            end
            if (tag_r_q) begin
              cap_right_o     <= word;
              cap_right_new_o <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer #(
  parameter int unsigned SLOT_W     = 16,
  parameter int unsigned FRM_BIT    = 15,
  parameter int unsigned CA_BIT     = 14,
  parameter int unsigned CD_BIT     = 13,
  parameter int unsigned L_VLD_BIT  = 12,
  parameter int unsigned R_VLD_BIT  = 11,
  localparam int unsigned BIT_IW    = $clog2(SLOT_W),
  localparam int unsigned NW        = tdm_pkg::ACTIVE_SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              active_i,
  input  logic [2:0]        slot_i,
  input  logic [BIT_IW-1:0] bit_i,
  input  logic [SLOT_W-1:0] pb_left_i,
  input  logic              pb_left_vld_i,
  input  logic [SLOT_W-1:0] pb_right_i,
  input  logic              pb_right_vld_i,
  input  logic [SLOT_W-1:0] cmd_addr_i,
  input  logic [SLOT_W-1:0] cmd_data_i,
  input  logic              cmd_vld_i,
  output logic              sdata_o
);
  typedef logic [SLOT_W-1:0] word_t;

  word_t fresh [NW];
  word_t frame_q [NW];
  word_t pb_l_q, pb_r_q, ca_q, cd_q, cur_w;
  logic  pend_l, pend_r, pend_c;

  always_comb begin
    fresh[0]            = '0;
    fresh[0][FRM_BIT]   = 1'b1;
    fresh[0][CA_BIT]    = pend_c;
    fresh[0][CD_BIT]    = pend_c;
    fresh[0][L_VLD_BIT] = pend_l;
    fresh[0][R_VLD_BIT] = pend_r;
    fresh[1]            = ca_q;
    fresh[2]            = cd_q;
    fresh[3]            = pb_l_q;
    fresh[4]            = pb_r_q;
  end

  // first bit of the frame is taken straight from the snapshot being loaded
  assign cur_w = fsync_i ? fresh[slot_i] : frame_q[slot_i];

  for (genvar k = 0; k < NW; k++) begin : g_frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      frame_q[k] <= '0;
      else if (fsync_i) frame_q[k] <= fresh[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdata_o <= 1'b0;
      pb_l_q  <= '0;
      pb_r_q  <= '0;
      ca_q    <= '0;
      cd_q    <= '0;
      pend_l  <= 1'b0;
      pend_r  <= 1'b0;
      pend_c  <= 1'b0;
    end else begin
      sdata_o <= active_i ? cur_w[bit_i] : 1'b0;
      if (pb_left_vld_i) begin
        pb_l_q <= pb_left_i;
        pend_l <= 1'b1;
      end else if (fsync_i) pend_l <= 1'b0;
      if (pb_right_vld_i) begin
        pb_r_q <= pb_right_i;
        pend_r <= 1'b1;
      end else if (fsync_i) pend_r <= 1'b0;
      if (cmd_vld_i) begin
        ca_q   <= cmd_addr_i;
        cd_q   <= cmd_data_i;
        pend_c <= 1'b1;
      end else if (fsync_i) pend_c <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_slot_handler.sv
module tdm_slot_handler #(
  parameter int unsigned SLOT_W    = 16,
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned BIT_IW   = $clog2(SLOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic [SLOT_W-1:0] stat_addr_o,
  output logic [SLOT_W-1:0] stat_data_o,
  output logic              dac_req_left_o,
  output logic              dac_req_right_o,
  output logic [SLOT_W-1:0] cap_left_o,
  output logic [SLOT_W-1:0] cap_right_o,
  output logic              cap_left_new_o,
  output logic              cap_right_new_o,
  input  logic [SLOT_W-1:0] pb_left_i,
  input  logic              pb_left_vld_i,
  input  logic [SLOT_W-1:0] pb_right_i,
  input  logic              pb_right_vld_i,
  input  logic [SLOT_W-1:0] cmd_addr_i,
  input  logic [SLOT_W-1:0] cmd_data_i,
  input  logic              cmd_vld_i
);
  logic              synced, active, last;
  logic [2:0]        slot_sel;
  logic [BIT_IW-1:0] bit_idx;

  tdm_bit_timer #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i),
    .synced_o(synced), .active_o(active), .last_o(last),
    .slot_o(slot_sel), .bit_o(bit_idx)
  );

  tdm_rx_deframer #(.SLOT_W(SLOT_W)) rx_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdata_i(sdata_i),
    .active_i(active), .last_i(last), .slot_i(slot_sel),
    .stat_addr_o(stat_addr_o), .stat_data_o(stat_data_o),
    .dac_req_left_o(dac_req_left_o), .dac_req_right_o(dac_req_right_o),
    .cap_left_o(cap_left_o), .cap_right_o(cap_right_o),
    .cap_left_new_o(cap_left_new_o), .cap_right_new_o(cap_right_new_o)
  );

  tdm_tx_framer #(.SLOT_W(SLOT_W)) tx_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i),
    .active_i(active), .slot_i(slot_sel), .bit_i(bit_idx),
    .pb_left_i(pb_left_i), .pb_left_vld_i(pb_left_vld_i),
    .pb_right_i(pb_right_i), .pb_right_vld_i(pb_right_vld_i),
    .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i), .cmd_vld_i(cmd_vld_i),
    .sdata_o(sdata_o)
  );
endmodule

// File: rtl/tdm_slot_handler_chk.sv
module tdm_slot_handler_chk #(
  parameter int unsigned SLOT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fsync_i,
  input logic              synced_i,
  input logic              active_i,
  input logic              sdata_o,
  input logic [SLOT_W-1:0] cap_left_o,
  input logic [SLOT_W-1:0] cap_right_o,
  input logic              cap_left_new_o,
  input logic              cap_right_new_o
);
  AST_LEFT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_left_new_o |=> !cap_left_new_o); // R3
  AST_RIGHT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_right_new_o |=> !cap_right_new_o); // R4
  AST_LEFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_left_new_o |-> $stable(cap_left_o)); // R5
  AST_RIGHT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_right_new_o |-> $stable(cap_right_o)); // R5
  AST_IDLE_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_i && !active_i) |=> !sdata_o); // R1
  AST_TAG_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> sdata_o); // R6
  AST_QUIET_UNSYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_i |=> (!sdata_o && !cap_left_new_o && !cap_right_new_o)); // R10
endmodule

bind tdm_slot_handler tdm_slot_handler_chk #(.SLOT_W(SLOT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i),
  .synced_i(synced), .active_i(active), .sdata_o(sdata_o),
  .cap_left_o(cap_left_o), .cap_right_o(cap_right_o),
  .cap_left_new_o(cap_left_new_o), .cap_right_new_o(cap_right_new_o)
);

// File: tb/tdm_slot_handler_tb_top.sv
module tdm_slot_handler_tb_top;
  localparam int SW = 16;
  localparam int NS = 8;
  localparam int FRAME = SW * NS;
  localparam int END_RX = 5 * SW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fsync_i = 1'b0, sdata_i = 1'b0;
  logic sdata_o;
  logic [SW-1:0] stat_addr_o, stat_data_o, cap_left_o, cap_right_o;
  logic dac_req_left_o, dac_req_right_o, cap_left_new_o, cap_right_new_o;
  logic [SW-1:0] pb_left_i = '0, pb_right_i = '0, cmd_addr_i = '0, cmd_data_i = '0;
  logic pb_left_vld_i = 1'b0, pb_right_vld_i = 1'b0, cmd_vld_i = 1'b0;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [SW-1:0] rxw [5];
  logic [SW-1:0] exp_tx [5];
  logic [SW-1:0] m_pbl = '0, m_pbr = '0, m_ca = '0, m_cd = '0;
  logic [SW-1:0] m_capl = '0, m_capr = '0;
  bit m_pl = 0, m_pr = 0, m_pc = 0;
  // per-frame stimulus
  int st_pos;
  bit st_l, st_r, st_c;
  logic [SW-1:0] st_vl, st_vr, st_va, st_vd;

  always #2.5 clk = ~clk;

  tdm_slot_handler #(.SLOT_W(SW), .NUM_SLOTS(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fsync_i(fsync_i), .sdata_i(sdata_i),
    .sdata_o(sdata_o), .stat_addr_o(stat_addr_o), .stat_data_o(stat_data_o),
    .dac_req_left_o(dac_req_left_o), .dac_req_right_o(dac_req_right_o),
    .cap_left_o(cap_left_o), .cap_right_o(cap_right_o),
    .cap_left_new_o(cap_left_new_o), .cap_right_new_o(cap_right_new_o),
    .pb_left_i(pb_left_i), .pb_left_vld_i(pb_left_vld_i),
    .pb_right_i(pb_right_i), .pb_right_vld_i(pb_right_vld_i),
    .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i), .cmd_vld_i(cmd_vld_i)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic exp_bit(input int q);
    if (q / SW < 5) return exp_tx[q / SW][SW - 1 - (q % SW)];
    return 1'b0;
  endfunction

  function automatic string tx_req(input int q);
    if (q == 0) return "R6 tag msb";
    if (q < SW) return "R7 R9 tag";
    if (q < 3 * SW) return "R8 cmd slot";
    if (q < 5 * SW) return "R7 R9 playback slot";
    return "R1 idle slot";
  endfunction

  task automatic run_frame(input logic [SW-1:0] tag, a, d, l, r);
    bit nl, nr;
    rxw[0] = tag; rxw[1] = a; rxw[2] = d; rxw[3] = l; rxw[4] = r;
    nl = tag[12];
    nr = tag[11];
    for (int p = 0; p < FRAME; p++) begin
      @(negedge clk);
      if (p > 0) begin
        check(sdata_o === exp_bit(p - 1), tx_req(p - 1), 32'(sdata_o), 32'(exp_bit(p - 1)));
      end
      if (p == END_RX) begin
        if (nl) m_capl = l;
        if (nr) m_capr = r;
        check(cap_left_new_o === nl, "R3 R5 left strobe", 32'(cap_left_new_o), 32'(nl));
        check(cap_right_new_o === nr, "R4 R5 right strobe", 32'(cap_right_new_o), 32'(nr));
        check(cap_left_o === m_capl, "R3 R5 left sample", 32'(cap_left_o), 32'(m_capl));
        check(cap_right_o === m_capr, "R4 R5 right sample", 32'(cap_right_o), 32'(m_capr));
        check(stat_addr_o === a, "R2 status address", 32'(stat_addr_o), 32'(a));
        check(stat_data_o === d, "R2 status data", 32'(stat_data_o), 32'(d));
        check(dac_req_left_o === a[7], "R2 left request", 32'(dac_req_left_o), 32'(a[7]));
        check(dac_req_right_o === a[6], "R2 right request", 32'(dac_req_right_o), 32'(a[6]));
      end else begin
        check(!cap_left_new_o, "R3 left strobe quiet", 32'(cap_left_new_o), 0);
        check(!cap_right_new_o, "R4 right strobe quiet", 32'(cap_right_new_o), 0);
      end
      // drive position p
      fsync_i = (p == 0);
      sdata_i = (p < END_RX) ? rxw[p / SW][SW - 1 - (p % SW)] : 1'b1;
      pb_left_vld_i = 1'b0; pb_right_vld_i = 1'b0; cmd_vld_i = 1'b0;
      if (p == 0) begin
        exp_tx[0] = '0;
        exp_tx[0][15] = 1'b1;
        exp_tx[0][14] = m_pc;
        exp_tx[0][13] = m_pc;
        exp_tx[0][12] = m_pl;
        exp_tx[0][11] = m_pr;
        exp_tx[1] = m_ca; exp_tx[2] = m_cd; exp_tx[3] = m_pbl; exp_tx[4] = m_pbr;
        m_pl = 0; m_pr = 0; m_pc = 0;
      end
      if (p == st_pos) begin
        if (st_l) begin pb_left_vld_i = 1'b1; pb_left_i = st_vl; m_pbl = st_vl; m_pl = 1; end
        if (st_r) begin pb_right_vld_i = 1'b1; pb_right_i = st_vr; m_pbr = st_vr; m_pr = 1; end
        if (st_c) begin
          cmd_vld_i = 1'b1; cmd_addr_i = st_va; cmd_data_i = st_vd;
          m_ca = st_va; m_cd = st_vd; m_pc = 1;
        end
      end
    end
  endtask

  task automatic set_strobe(input int pos, input bit l, r, c,
                            input logic [SW-1:0] vl, vr, va, vd);
    st_pos = pos; st_l = l; st_r = r; st_c = c;
    st_vl = vl; st_vr = vr; st_va = va; st_vd = vd;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R10: reset and pre-sync quiet
    repeat (3) @(negedge clk);
    check(sdata_o === 1'b0 && cap_left_o === '0 && cap_right_o === '0 && stat_addr_o === '0,
          "R10 reset state", 32'(cap_left_o), 0);
    rst_ni = 1'b1;
    sdata_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(sdata_o === 1'b0, "R10 unsynced tx", 32'(sdata_o), 0);
      check(!cap_left_new_o && !cap_right_new_o, "R10 unsynced strobes",
            32'({cap_left_new_o, cap_right_new_o}), 0);
    end
    // frame 1: both valid; playback strobe late in frame
    set_strobe(100, 1, 1, 0, 16'hA1A1, 16'hB2B2, 0, 0);
    run_frame(16'h9800, 16'h00C0, 16'h5A5A, 16'h1111, 16'h2222);
    // frame 2: none valid; command strobe mid-frame
    set_strobe(20, 0, 0, 1, 0, 0, 16'h1234, 16'hABCD);
    run_frame(16'h8000, 16'h0080, 16'h0F0F, 16'h3333, 16'h4444);
    // frame 3: left only; left strobe on the sync edge
    set_strobe(0, 1, 0, 0, 16'h7777, 0, 0, 0);
    run_frame(16'h1000, 16'h0040, 16'hF00D, 16'h5555, 16'h6666);
    // frame 4: right only; right strobe inside slot 3
    set_strobe(60, 0, 1, 0, 0, 16'hC3C3, 0, 0);
    run_frame(16'h0800, 16'h0000, 16'h1357, 16'h8888, 16'h9999);
    // frame 5: both valid, no strobes
    set_strobe(-1, 0, 0, 0, 0, 0, 0, 0);
    run_frame(16'h1800, 16'hFFFF, 16'h2468, 16'hDEAD, 16'hBEEF);
    // frame 6: none valid, all-ones data
    run_frame(16'h0000, 16'h1234, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    run_frame(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule